// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines into one interrupt output for a processor. A rising edge on a request line is latched into a pending bit for that line. The line with the lowest index has the highest priority. The controller forwards a pending line to the processor only when that line outranks every line the processor is already servicing. Because of this, a more urgent source can interrupt the handler of a less urgent one, while less urgent sources wait.

The processor pulses an acknowledge to claim the winning line. The controller then moves that line from pending to in-service and reports its index on a vector output for one cycle. When a handler finishes, the processor pulses end-of-service. This retires the most urgent level in service, which unblocks lines of lower priority. A mask, loaded through a write strobe, holds chosen lines back from the output without dropping their pending state.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset no line is pending, in service or masked, `irq_out` is 0 and `vec_valid` is 0.
- R2: A 0-to-1 transition on `req_in[i]` between two clock edges sets pending bit i at the second edge, so a single-cycle pulse is kept. A level held high sets the bit only once.
- R3: Priority is fixed by index: line 0 ranks highest and line N-1 lowest. When several lines are eligible, an acknowledge takes the one with the smallest index.
- R4: `irq_out` is 1 exactly when some pending, unmasked line has a smaller index than every in-service line (any line qualifies when nothing is in service). `irq_out` depends only on registered state.
- R5: An acknowledge in a cycle with `irq_out`=1 clears the winner's pending bit and sets its in-service bit. In the next cycle it drives `vec_valid`=1 with `vec_out` equal to the winner's index. An acknowledge while `irq_out`=0 changes nothing, and `vec_valid` stays 0.
- R6: A pending line with a smaller index than every in-service line is forwarded while a lower-priority handler is in service (nesting).
- R7: A pending line whose index is equal to or greater than that of some in-service line stays pending and is not forwarded. It is forwarded once end-of-service has retired every in-service line that outranks it or shares its index.
- R8: `eoi_in` clears only the in-service bit with the smallest index. With nothing in service it has no effect.
- R9: `mask_we`=1 loads `mask_wdata` at the clock edge. A mask bit of 1 keeps its line from being forwarded, and the line stays pending so it is forwarded once unmasked.
- R10: Several edges on a line that is already pending merge into one pending bit, and one acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | N_LINES | Interrupt request lines, rising-edge sensitive |
| mask_we | input | 1 | Load strobe for the mask |
| mask_wdata | input | N_LINES | New mask value, 1 blocks a line |
| ack_in | input | 1 | Acknowledge pulse from the processor |
| eoi_in | input | 1 | End-of-service pulse from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector output valid for one cycle after a granted acknowledge |
| vec_out | output | VEC_W | Index of the acknowledged line |

## Verification
The assertions assume that every input is synchronous to `clk` and stays stable around the rising edge. They also assume that `ack_in` and `eoi_in` are single-cycle strobes sampled at one edge each. Acknowledge and end-of-service may arrive in the same cycle, and the in-service count checks exclude that case. The bench changes every input only on the falling edge. It sends end-of-service at random, including when nothing is in service. This covers the no-effect case without breaking the assumptions.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned NIC_DEF_LINES = 8;

  function automatic int unsigned nic_idx_width(input int unsigned lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction
endpackage

// File: rtl/nic_edge_capture.sv
module nic_edge_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= 1'b0;
      else        lvl_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
  end
endmodule

// File: rtl/nic_prio_pick.sv
module nic_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o,
  output logic [N-1:0]  above_o
);
  // index of the lowest set bit (highest priority); 0 when empty
  function automatic logic [IW-1:0] first_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  // lines strictly more urgent than the lowest set bit; all lines when empty
  function automatic logic [N-1:0] outrank(input logic [N-1:0] v);
    logic [N-1:0] r;
    logic         seen;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      r[i] = ~seen;
      if (v[i]) seen = 1'b1;
      r[i] = r[i] & ~v[i];
    end
    return r;
  endfunction

  assign any_o    = |vec_i;
  assign idx_o    = first_idx(vec_i);
  assign onehot_o = vec_i & ~(vec_i - N'(1));
  assign above_o  = outrank(vec_i);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int unsigned N_LINES = nic_pkg::NIC_DEF_LINES,
  parameter int unsigned VEC_W   = nic_pkg::nic_idx_width(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_in,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               ack_in,
  input  logic               eoi_in,
  output logic               irq_out,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out
);
  localparam int unsigned N = N_LINES;

  logic [N-1:0]     pend_q, isr_q, mask_q;
  logic [N-1:0]     rise_w, elig_w, grant_w, eoi_clr_w;
  logic [N-1:0]     isr_top_w, isr_above_w, elig_top_w, elig_above_w;
  logic             isr_any_w, elig_any_w;
  logic [VEC_W-1:0] isr_idx_w, elig_idx_w;

  nic_edge_capture #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(req_in), .rise_o(rise_w)
  );

  nic_prio_pick #(.N(N), .IW(VEC_W)) u_isr_pick (
    .vec_i(isr_q), .any_o(isr_any_w), .idx_o(isr_idx_w),
    .onehot_o(isr_top_w), .above_o(isr_above_w)
  );

  assign elig_w = pend_q & ~mask_q & isr_above_w;

  nic_prio_pick #(.N(N), .IW(VEC_W)) u_req_pick (
    .vec_i(elig_w), .any_o(elig_any_w), .idx_o(elig_idx_w),
    .onehot_o(elig_top_w), .above_o(elig_above_w)
  );

  assign grant_w   = (ack_in && elig_any_w) ? elig_top_w : '0;
  assign eoi_clr_w = eoi_in ? isr_top_w : '0;
  assign irq_out   = elig_any_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      pend_q    <= (pend_q & ~grant_w) | rise_w;
      isr_q     <= (isr_q & ~eoi_clr_w) | grant_w;
      vec_valid <= |grant_w;
      if (|grant_w) vec_out <= elig_idx_w;
      if (mask_we)  mask_q  <= mask_wdata;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_in,
  input logic          eoi_in,
  input logic          irq_out,
  input logic          vec_valid,
  input logic [IW-1:0] vec_out,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  rise_w,
  input logic [N-1:0]  grant_w
);
  assert_vec_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_in));

  assert_vec_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> isr_q[vec_out]);

  assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pend_q & ~mask_q) != '0));

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));

  assert_grant_adds_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq_out && !eoi_in) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

  assert_eoi_drops_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_in && !ack_in && isr_q != '0) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

  assert_edge_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w != '0) |=> ((pend_q & $past(rise_w)) == $past(rise_w)));
endmodule

bind nest_irq_ctrl nic_checker #(.N(N_LINES), .IW(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .eoi_in(eoi_in),
  .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out),
  .pend_q(pend_q), .isr_q(isr_q), .mask_q(mask_q),
  .rise_w(rise_w), .grant_w(grant_w)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       ack_in = 1'b0;
  logic       eoi_in = 1'b0;
  logic       irq_out, vec_valid;
  logic [2:0] vec_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit running = 0;

  always #10 clk = ~clk;

  nest_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ack_in(ack_in), .eoi_in(eoi_in),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // behavioural reference model
  bit [7:0] m_pend, m_isr, m_mask, m_prev;
  bit       m_vv;
  int       m_vec;

  function automatic int top_isr();
    for (int i = 0; i < 8; i++) if (m_isr[i]) return i;
    return 8;
  endfunction

  function automatic int winner();
    int t = top_isr();
    for (int i = 0; i < t; i++) if (m_pend[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_isr = '0; m_mask = '0; m_prev = '0; m_vv = 0; m_vec = 0;
    end else begin
      int t, w;
      t = top_isr();
      w = winner();
      m_vv = 0;
      if (eoi_in && t < 8) m_isr[t] = 1'b0;
      if (ack_in && w >= 0) begin
        m_pend[w] = 1'b0; m_isr[w] = 1'b1; m_vv = 1; m_vec = w;
      end
      for (int i = 0; i < 8; i++) if (req_in[i] && !m_prev[i]) m_pend[i] = 1'b1;
      m_prev = req_in;
      if (mask_we) m_mask = mask_wdata;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (running) begin
      check("R4 irq_out vs model", irq_out, (winner() >= 0) ? 1 : 0);
      check("R5 vec_valid vs model", vec_valid, m_vv);
      if (m_vv) check("R5 vec_out vs model", vec_out, m_vec);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input int line);
    req_in[line] = 1'b1; step(); req_in[line] = 1'b0; step();
  endtask

  task automatic ack();
    ack_in = 1'b1; step(); ack_in = 1'b0;
  endtask

  task automatic eoi();
    eoi_in = 1'b1; step(); eoi_in = 1'b0; step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) step();
    check("R1 irq after reset", irq_out, 0);
    check("R1 vec_valid after reset", vec_valid, 0);
    rst_n = 1'b1;
    step();
    running = 1;

    // R2: a single-cycle pulse is latched
    pulse(5);
    check("R2 pulse latched", irq_out, 1);
    ack();
    check("R5 vec_valid", vec_valid, 1);
    check("R5 vec_out", vec_out, 5);
    step();
    check("R5 vec_valid one cycle", vec_valid, 0);
    check("R7 nothing left", irq_out, 0);

    // R7: lower priority waits behind line 5
    pulse(6);
    check("R7 lower held", irq_out, 0);
    // R6: higher priority nests
    pulse(2);
    check("R6 nesting forwards", irq_out, 1);
    ack();
    check("R6 nested vector", vec_out, 2);
    step();
    eoi();
    check("R8 eoi retires 2 only, 5 still blocks 6", irq_out, 0);
    eoi();
    check("R7 released after eoi", irq_out, 1);
    ack();
    check("R7 vector", vec_out, 6);
    step(); eoi();

    // R9: mask holds line back but keeps it pending
    mask_wdata = 8'h08; mask_we = 1'b1; step(); mask_we = 1'b0;
    pulse(3);
    check("R9 masked line blocked", irq_out, 0);
    mask_wdata = 8'h00; mask_we = 1'b1; step(); mask_we = 1'b0; step();
    check("R9 unmasked forwarded", irq_out, 1);
    ack(); check("R9 vector", vec_out, 3); step(); eoi();

    // R10: merged edges, one acknowledge clears
    pulse(4); pulse(4);
    ack(); check("R10 vector", vec_out, 4); step();
    check("R10 merged, none left", irq_out, 0);
    eoi();

    // R3: simultaneous requests, lowest index wins
    req_in = 8'h03; step(); req_in = 8'h00; step();
    ack(); check("R3 priority winner", vec_out, 0); step();
    check("R7 equal-or-lower blocked by 0", irq_out, 0);
    ack(); check("R5 ack ignored when idle", vec_valid, 0); step();
    eoi();
    ack(); check("R3 next winner", vec_out, 1); step(); eoi();

    // R2: held level captured once; retrigger of in-service line waits
    req_in[7] = 1'b1; step(); step(); step();
    ack(); check("R2 held level vector", vec_out, 7); step();
    check("R2 held level not recaptured", irq_out, 0);
    req_in[7] = 1'b0; step();
    eoi();
    pulse(3); ack(); step(); pulse(3);
    check("R7 same line waits for eoi", irq_out, 0);
    eoi();
    check("R7 same line after eoi", irq_out, 1);
    ack(); step(); eoi();
    eoi();
    check("R8 eoi with nothing in service", irq_out, 0);

    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      req_in     = 8'($urandom) & 8'($urandom) & 8'($urandom);
      ack_in     = ($urandom_range(0, 3) == 0);
      eoi_in     = ($urandom_range(0, 4) == 0);
      mask_we    = ($urandom_range(0, 40) == 0);
      mask_wdata = 8'($urandom) & 8'($urandom);
      step();
    end
    req_in = '0; ack_in = 0; eoi_in = 0; mask_we = 0;
    step(); step();
    summary();
  end
endmodule